// File: doc/BRIEF.md
# Quadrature Pointer Position Counters

This block tracks the motion of two pointing controllers. Each controller port has an X axis and a Y axis. Each axis is driven by a pair of quadrature lines. Every axis keeps a 6-bit up/down position count. The count moves one step for each legal Gray-code change of its pair. The count is wrapped in an 8-bit axis byte whose two low bits show the live, registered state of the pair.

Software reads one port at a time as a 16-bit word. The same word can be decoded as four digital joystick switches, and the block also drives those decoded direction signals directly. A test write presets the count field of all four axes in one cycle.

Each axis is a small state machine. Its state is the last registered quadrature phase, one of PH_00, PH_01, PH_11 and PH_10. From each phase it takes one of four named transitions against the newest sample:
- STEP_HOLD: the phase is unchanged.
- STEP_UP: the forward neighbour was reached.
- STEP_DOWN: the reverse neighbour was reached.
- STEP_BAD: both lines changed at once.

Top module: `qpos_counters`

## Requirements
- R1: `rd_data` returns the port chosen by `rd_sel` (0 or 1), with the Y axis byte in bits 15:8 and the X axis byte in bits 7:0; the read path is combinational.
- R2: Bits 7:2 of an axis byte hold a 6-bit count. With the pair written as {b,a}, the sequence 00→01→11→10→00 adds one per step and the reverse order subtracts one. The count wraps modulo 64. A step is visible two clock edges after the input change.
- R3: Bits 1:0 of an axis byte show the pair registered at the last edge, bit 0 = line a and bit 1 = line b. `quad_in[4p+0]`, `[4p+1]`, `[4p+2]` and `[4p+3]` are X a, X b, Y a and Y b of port p.
- R4: A sample in which both lines of a pair differ from the previous sample leaves that count unchanged.
- R5: A cycle with `tst_wr` high loads `tst_data[7:2]` into every X count and `tst_data[15:10]` into every Y count, visible after that edge. Bits 9:8 and 1:0 of the written word are ignored and the low bits keep showing the raw pair.
- R6: When a test write and a count step fall on the same edge, the written value is kept and the step is lost.
- R7: Per port, `dir_fwd` = Y1 xor Y0, `dir_left` = Y1, `dir_back` = X1 xor X0, `dir_right` = X1, taken from that port's axis bytes.
- R8: While `rst_n` is low, all counts and registered pairs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quad_in | input | 8 | Deserialized quadrature lines, four per port |
| rd_sel | input | 1 | Port selected for reading |
| rd_data | output | 16 | Selected port word, Y byte high, X byte low |
| tst_wr | input | 1 | Test write strobe |
| tst_data | input | 16 | Test write value |
| dir_fwd | output | 2 | Forward switch per port |
| dir_left | output | 2 | Left switch per port |
| dir_back | output | 2 | Back switch per port |
| dir_right | output | 2 | Right switch per port |

## Verification
A test write and a quadrature count step can land on the same clock edge. The bench provokes this by changing one X line, waiting one edge so the new sample is registered, and then raising the write strobe for exactly the edge on which the step would be applied. The word read afterwards must carry the written count and the new raw pair bits. A second read one cycle later must show that the lost step does not reappear.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

    // Registered quadrature phase, encoded as {b,a}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_e;

    // Transition taken from the previous phase to the newest sample
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;

    function automatic phase_e phase_fwd(input phase_e p);
        unique case (p)
            PH_00: phase_fwd = PH_01;
            PH_01: phase_fwd = PH_11;
            PH_11: phase_fwd = PH_10;
            PH_10: phase_fwd = PH_00;
        endcase
    endfunction

    function automatic phase_e phase_rev(input phase_e p);
        unique case (p)
            PH_00: phase_rev = PH_10;
            PH_10: phase_rev = PH_11;
            PH_11: phase_rev = PH_01;
            PH_01: phase_rev = PH_00;
        endcase
    endfunction

endpackage

// File: rtl/qpos_axis.sv
module qpos_axis
    import qpos_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         pair_i,
    input  logic               ld_i,
    input  logic [CNT_W-1:0]   ld_val_i,
    output logic [CNT_W+1:0]   byte_o
);

    phase_e           cur_q;
    phase_e           prv_q;
    logic [CNT_W-1:0] cnt_q;
    step_e            step;

    // State register: sample, previous sample, count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= PH_00;
            prv_q <= PH_00;
            cnt_q <= '0;
        end else begin
            cur_q <= phase_e'(pair_i);
            prv_q <= cur_q;
            if (ld_i) begin
                cnt_q <= ld_val_i;
            end else begin
                unique case (step)
                    STEP_UP:   cnt_q <= cnt_q + CNT_W'(1);
                    STEP_DOWN: cnt_q <= cnt_q - CNT_W'(1);
                    STEP_HOLD,
                    STEP_BAD:  cnt_q <= cnt_q;
                endcase
            end
        end
    end

    // Transition decode
    always_comb begin
        if (cur_q == prv_q)                 step = STEP_HOLD;
        else if (cur_q == phase_fwd(prv_q)) step = STEP_UP;
        else if (cur_q == phase_rev(prv_q)) step = STEP_DOWN;
        else                                step = STEP_BAD;
    end

    // Output word
    always_comb begin
        byte_o = {cnt_q, 2'(cur_q)};
    end

    // R3: low bits follow the registered pair
    p_raw_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (2'(cur_q) == $past(pair_i)));

    // R5, R6: a test write wins over any step
    p_test_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_q == $past(ld_val_i)));

    // R2: without a write the count moves by at most one
    p_step_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)
                   || cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R4: a double change leaves the count alone
    p_double_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && ((2'(cur_q) ^ 2'(prv_q)) == 2'b11)) |=> $stable(cnt_q));

endmodule

// File: rtl/qpos_dirdec.sv
module qpos_dirdec #(
    parameter int AXIS_W = 8
) (
    input  logic [AXIS_W-1:0] x_byte_i,
    input  logic [AXIS_W-1:0] y_byte_i,
    output logic              fwd_o,
    output logic              left_o,
    output logic              back_o,
    output logic              right_o
);

    always_comb begin
        fwd_o   = y_byte_i[1] ^ y_byte_i[0];
        left_o  = y_byte_i[1];
        back_o  = x_byte_i[1] ^ x_byte_i[0];
        right_o = x_byte_i[1];
    end

endmodule

// File: rtl/qpos_counters.sv
module qpos_counters #(
    parameter int PORTS  = 2,
    parameter int CNT_W  = 6,
    localparam int AXIS_W = CNT_W + 2,
    localparam int WORD_W = 2 * AXIS_W,
    localparam int LINE_W = 4 * PORTS,
    localparam int SEL_W  = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] quad_in,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic              tst_wr,
    input  logic [WORD_W-1:0] tst_data,
    output logic [PORTS-1:0]  dir_fwd,
    output logic [PORTS-1:0]  dir_left,
    output logic [PORTS-1:0]  dir_back,
    output logic [PORTS-1:0]  dir_right
);

    logic [WORD_W-1:0] words [PORTS];

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic [AXIS_W-1:0] x_byte;
        logic [AXIS_W-1:0] y_byte;

        qpos_axis #(.CNT_W(CNT_W)) i_x (
            .clk      (clk),
            .rst_n    (rst_n),
            .pair_i   (quad_in[4*p+1 : 4*p]),
            .ld_i     (tst_wr),
            .ld_val_i (tst_data[AXIS_W-1:2]),
            .byte_o   (x_byte)
        );

        qpos_axis #(.CNT_W(CNT_W)) i_y (
            .clk      (clk),
            .rst_n    (rst_n),
            .pair_i   (quad_in[4*p+3 : 4*p+2]),
            .ld_i     (tst_wr),
            .ld_val_i (tst_data[WORD_W-1:AXIS_W+2]),
            .byte_o   (y_byte)
        );

        qpos_dirdec #(.AXIS_W(AXIS_W)) i_dir (
            .x_byte_i (x_byte),
            .y_byte_i (y_byte),
            .fwd_o    (dir_fwd[p]),
            .left_o   (dir_left[p]),
            .back_o   (dir_back[p]),
            .right_o  (dir_right[p])
        );

        assign words[p] = {y_byte, x_byte};
    end

    // R1: port word select
    always_comb begin
        rd_data = words[rd_sel];
    end

endmodule

// File: tb/test_qpos_counters.sv
module test_qpos_counters;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // {quad_in, expected port 0 word, expected port 1 word}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'h01, 16'h0005, 16'h0000},  // R2 R3 up step
        {8'h03, 16'h000B, 16'h0000},
        {8'h02, 16'h000E, 16'h0000},
        {8'h00, 16'h0010, 16'h0000},  // full cycle
        {8'h02, 16'h000E, 16'h0000},  // R2 down step
        {8'h01, 16'h000D, 16'h0000},  // R4 double change
        {8'h05, 16'h050D, 16'h0000},  // R1 Y byte
        {8'h15, 16'h050D, 16'h0005},  // R1 port 1
        {8'h95, 16'h050D, 16'hFE05},  // R2 wrap down
        {8'h35, 16'h050D, 16'h000B}   // two axes at once
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  quad_in = '0;
    logic [0:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        tst_wr = 1'b0;
    logic [15:0] tst_data = '0;
    logic [1:0]  dir_fwd, dir_left, dir_back, dir_right;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qpos_counters i_qpos_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .quad_in   (quad_in),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .tst_wr    (tst_wr),
        .tst_data  (tst_data),
        .dir_fwd   (dir_fwd),
        .dir_left  (dir_left),
        .dir_back  (dir_back),
        .dir_right (dir_right)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_ports(input string req, input logic [15:0] e0, input logic [15:0] e1);
        rd_sel = 1'b0;
        #1 check(req, rd_data, e0);
        rd_sel = 1'b1;
        #1 check(req, rd_data, e1);
    endtask

    task automatic test_write(input logic [15:0] val);
        tst_wr   = 1'b1;
        tst_data = val;
        @(negedge clk);
        tst_wr   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check_ports("R8 reset", 16'h0000, 16'h0000);
        check("R8 dirs", {8'h00, dir_fwd, dir_left, dir_back, dir_right}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            quad_in = VEC[i][39:32];
            repeat (2) @(negedge clk);
            check_ports($sformatf("R2 vector %0d", i), VEC[i][31:16], VEC[i][15:0]);
        end

        // R7 direction decode, quad 0x35
        check("R7 dirs", {8'h00, dir_fwd, dir_left, dir_back, dir_right}, {8'h00, 2'b01, 2'b00, 2'b01, 2'b10});

        // R5 load all four counts
        test_write(16'hFFFF);
        check_ports("R5 load", 16'hFDFD, 16'hFCFF);

        // R2 wrap up from 63
        quad_in = 8'h75;
        repeat (2) @(negedge clk);
        check_ports("R2 wrap up", 16'hFDFD, 16'h01FF);

        // R5 ignored bits keep the raw pair
        test_write(16'h0303);
        check_ports("R5 ignored bits", 16'h0101, 16'h0103);

        // R6 write on the step edge
        quad_in = 8'h77;
        @(negedge clk);
        test_write(16'h0800);
        check_ports("R6 priority", 16'h0903, 16'h0903);
        @(negedge clk);
        check_ports("R6 no late step", 16'h0903, 16'h0903);

        // R7 direction decode, quad 0x77
        check("R7 dirs 2", {8'h00, dir_fwd, dir_left, dir_back, dir_right}, {8'h00, 2'b11, 2'b00, 2'b00, 2'b11});

        // R8 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check_ports("R8 reset again", 16'h0000, 16'h0000);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule